// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Core

This block takes eight interrupt request lines and turns them into one interrupt flag plus the number of the line that should be serviced next. Each line can be set individually to level or edge capture. Captured requests pass through a mask and are compared against the lines already in service. The comparison uses a priority order that starts at a movable base line and wraps around all eight lines.

The processor side acknowledges the reported line with a strobe. This moves the line into service, or, in automatic end-of-interrupt mode, can move the priority base past that line. Later commands retire in-service lines and can rotate or set the priority base. The mask register is loaded through a write strobe. Its value, the request register, the in-service register and the priority base are all visible at the ports. Programming sequences and chaining several such cores together are left to surrounding logic.

Top module: `irq_prio_core`

## Requirements
- R1: For a line whose `trig_level` bit is 0 (edge mode), the request bit is set on the clock edge at which `req_in` is sampled 1 while the previous sample of that input was 0. Holding the input at 1 does not set the bit again after it is cleared.
- R2: For a line whose `trig_level` bit is 1 (level mode), the request bit takes the sampled value of `req_in` on every clock edge.
- R3: While `rst_n` is low, the request, previous-level, mask and in-service registers are zero and the priority base is zero.
- R4: The candidate set is the request register with the masked lines removed. `int_out` is 1 exactly when the best candidate's relative priority is strictly smaller than the best in-service relative priority. Relative priority is (line − base) mod 8, and an empty set counts as 8.
- R5: `int_line` equals (relative priority of the best candidate + base) mod 8.
- R6: When `ack` is high, `int_out` is 1 and `auto_eoi` is 0, the in-service bit of `int_line` is set on that clock edge.
- R7: When `ack` is high, `int_out` is 1 and `auto_eoi` is 1, no in-service bit is set. If `rot_on_aeoi` is also 1, the base becomes (`int_line` + 1) mod 8; otherwise the base is unchanged.
- R8: An accepted acknowledge clears the request bit of `int_line` only if that line is in edge mode. A level-mode request bit stays set while its input stays high.
- R9: Command code 1 clears the in-service bit with the best relative priority, if any. Code 2 does the same and also sets the base to (cleared line + 1) mod 8.
- R10: Command code 3 clears the in-service bit of `cmd_line`. Code 4 also sets the base to (`cmd_line` + 1) mod 8.
- R11: Command code 5 sets the base to (`cmd_line` + 1) mod 8. Codes 0, 6 and 7 change nothing.
- R12: When a command and an accepted acknowledge fall in the same cycle, the command's clear is applied first and the acknowledge's set last. When both change the base, the acknowledge's value wins.
- R13: `ack` while `int_out` is 0 changes no register.
- R14: `mask_we` loads `mask_data` into the mask register on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Per-line capture mode, 1 = level, 0 = edge |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | New mask value, 1 = line masked |
| ack | input | 1 | Acknowledge strobe for the reported line |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_on_aeoi | input | 1 | Rotate base on automatic end-of-interrupt |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R9 to R11) |
| cmd_line | input | 3 | Line operand of a command |
| int_out | output | 1 | Interrupt request to the processor |
| int_line | output | 3 | Line number of the winning request |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| prio_base | output | 3 | Current priority base line |

## Verification
The bench keeps its own model and goes after the corner cases where the wraparound of the priority base matters. A design that compared priorities by absolute line number would report the wrong winner once the base moves away from zero. One that used "less or equal" against the in-service level would let a line interrupt itself. Level lines that are acknowledged must keep their request bit, and a design that cleared it would lose a still-asserted interrupt. An edge line held high must not re-trigger, and a design without the previous-level copy would fire on every cycle. Same-cycle command and acknowledge must leave the acknowledged line in service. Automatic end-of-interrupt must move the base only when rotation is enabled. Sweeps across all eight base values and every command code catch off-by-one errors in the (line + 1) rotation and in the non-specific clear.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    OP_NOP          = 3'd0,
    OP_EOI_ANY      = 3'd1,
    OP_EOI_ANY_ROT  = 3'd2,
    OP_EOI_LINE     = 3'd3,
    OP_EOI_LINE_ROT = 3'd4,
    OP_SET_BASE     = 3'd5
  } irq_op_e;
endpackage

// File: rtl/irq_prio_resolve.sv
// Rotating priority search: relative index 0 is the line at the base.
module irq_prio_resolve #(
  parameter int NL = 8,
  localparam int LW = $clog2(NL),
  localparam int PW = $clog2(NL + 1)
) (
  input  logic [NL-1:0] vec,
  input  logic [LW-1:0] base,
  output logic [PW-1:0] rel,
  output logic [LW-1:0] line,
  output logic          hit
);
  function automatic logic [LW-1:0] wrap_add(input int a, input int b);
    int s;
    s = a + b;
    if (s >= NL) s = s - NL;
    return LW'(s);
  endfunction

  always_comb begin
    rel = PW'(NL);
    for (int i = NL - 1; i >= 0; i--) begin
      if (vec[wrap_add(i, int'(base))]) rel = PW'(i);
    end
    line = wrap_add(int'(rel), int'(base));
    hit  = (rel != PW'(NL));
  end
endmodule

// File: rtl/irq_req_capture.sv
// Per-line request capture, edge or level, with acknowledge clear for edge lines.
module irq_req_capture #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] req_in,
  input  logic [NL-1:0] trig_level,
  input  logic [NL-1:0] ack_clr,
  output logic [NL-1:0] irr,
  output logic [NL-1:0] rise
);
  logic [NL-1:0] prev_q;

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign rise[g] = req_in[g] & ~prev_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        irr[g]    <= 1'b0;
      end else begin
        prev_q[g] <= req_in[g];
        if (trig_level[g]) irr[g] <= req_in[g];
        else               irr[g] <= (irr[g] & ~ack_clr[g]) | rise[g];
      end
    end

    // R1: an edge on an edge-mode line is captured
    p_edge_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[g] && req_in[g] && !prev_q[g]) |=> irr[g]);
    // R2: a level-mode line copies the input
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_level[g] |=> (irr[g] == $past(req_in[g])));
    // R8: acknowledge clears an edge line absent a fresh edge
    p_edge_ack_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[g] && !trig_level[g] && !(req_in[g] && !prev_q[g])) |=> !irr[g]);
  end
endmodule

// File: rtl/irq_isr_ctrl.sv
// In-service register and priority base, updated by commands and acknowledge.
module irq_isr_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_line,
  input  logic          isr_hit,
  input  logic [LW-1:0] isr_line,
  input  logic          ack_fire,
  input  logic [LW-1:0] ack_line,
  input  logic          auto_eoi,
  input  logic          rot_on_aeoi,
  output logic [NL-1:0] isr,
  output logic [LW-1:0] base
);
  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l);
    int s;
    s = int'(l) + 1;
    if (s >= NL) s = 0;
    return LW'(s);
  endfunction

  irq_op_e       op;
  logic [NL-1:0] isr_nxt;
  logic [LW-1:0] base_nxt;

  assign op = irq_op_e'(cmd_op);

  always_comb begin
    isr_nxt  = isr;
    base_nxt = base;
    if (cmd_valid) begin
      unique case (op)
        OP_EOI_ANY:      if (isr_hit) isr_nxt[isr_line] = 1'b0;
        OP_EOI_ANY_ROT:  if (isr_hit) begin
                           isr_nxt[isr_line] = 1'b0;
                           base_nxt = next_line(isr_line);
                         end
        OP_EOI_LINE:     isr_nxt[cmd_line] = 1'b0;
        OP_EOI_LINE_ROT: begin
                           isr_nxt[cmd_line] = 1'b0;
                           base_nxt = next_line(cmd_line);
                         end
        OP_SET_BASE:     base_nxt = next_line(cmd_line);
        default:         ;
      endcase
    end
    if (ack_fire) begin
      if (!auto_eoi)        isr_nxt[ack_line] = 1'b1;
      else if (rot_on_aeoi) base_nxt = next_line(ack_line);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= '0;
      base <= '0;
    end else begin
      isr  <= isr_nxt;
      base <= base_nxt;
    end
  end

  // R6, R12: an accepted acknowledge leaves its line in service
  p_ack_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !auto_eoi) |=> isr[$past(ack_line)]);
  // R7: automatic end-of-interrupt sets no in-service bit
  p_aeoi_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && auto_eoi && !cmd_valid) |=> (isr == $past(isr)));
  // R11: unknown command codes leave state alone
  p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd0 || cmd_op > 3'd5) && !ack_fire)
      |=> ($stable(isr) && $stable(base)));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NL = 8,
  localparam int LW = $clog2(NL),
  localparam int PW = $clog2(NL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] req_in,
  input  logic [NL-1:0] trig_level,
  input  logic          mask_we,
  input  logic [NL-1:0] mask_data,
  input  logic          ack,
  input  logic          auto_eoi,
  input  logic          rot_on_aeoi,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_line,
  output logic          int_out,
  output logic [LW-1:0] int_line,
  output logic [NL-1:0] irr,
  output logic [NL-1:0] isr,
  output logic [NL-1:0] imr,
  output logic [LW-1:0] prio_base
);
  logic [NL-1:0] cand, ack_clr, rise;
  logic [PW-1:0] cand_rel, svc_rel;
  logic [LW-1:0] svc_line;
  logic          cand_hit, svc_hit, ack_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       imr <= '0;
    else if (mask_we) imr <= mask_data;
  end

  assign cand     = irr & ~imr;
  assign int_out  = cand_rel < svc_rel;
  assign ack_fire = ack & int_out;
  assign ack_clr  = ack_fire ? (NL'(1) << int_line) : '0;

  irq_req_capture #(.NL(NL)) u_capture (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .ack_clr(ack_clr), .irr(irr), .rise(rise)
  );

  irq_prio_resolve #(.NL(NL)) u_cand (
    .vec(cand), .base(prio_base), .rel(cand_rel), .line(int_line), .hit(cand_hit)
  );

  irq_prio_resolve #(.NL(NL)) u_svc (
    .vec(isr), .base(prio_base), .rel(svc_rel), .line(svc_line), .hit(svc_hit)
  );

  irq_isr_ctrl #(.NL(NL)) u_isr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .isr_hit(svc_hit), .isr_line(svc_line),
    .ack_fire(ack_fire), .ack_line(int_line), .auto_eoi(auto_eoi),
    .rot_on_aeoi(rot_on_aeoi), .isr(isr), .base(prio_base)
  );

  // R4: a raised interrupt names a pending, unmasked line
  p_int_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (cand_hit && irr[int_line] && !imr[int_line]));
  // R4: an interrupt never names a line already in service
  p_int_not_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !isr[int_line]);
  // R13: acknowledge without an interrupt leaves the in-service register alone
  p_ack_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !cmd_valid) |=> $stable(isr));
  // R14: mask load
  p_mask_load_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (imr == $past(mask_data)));
  // R1: edge on an unmasked edge line never goes unreported while nothing is in service
  p_rise_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & ~trig_level & ~mask_data) && mask_we && $countones(isr) == 0)
      |=> (|(irr & ~imr)));
endmodule

// File: tb/test_irq_prio_core.sv
module test_irq_prio_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, trig_level = '0, mask_data = '0;
  logic       mask_we = 1'b0, ack = 1'b0, auto_eoi = 1'b0, rot_on_aeoi = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_line = '0;
  logic       int_out;
  logic [2:0] int_line, prio_base;
  logic [7:0] irr, isr, imr;

  int checks = 0, fails = 0;

  // bench model
  logic [7:0] m_irr = '0, m_prev = '0, m_isr = '0, m_imr = '0;
  logic [2:0] m_base = '0;
  logic [7:0] n_irr, n_prev, n_isr, n_imr;
  logic [2:0] n_base;

  always #2 clk = ~clk;

  irq_prio_core i_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .mask_we(mask_we), .mask_data(mask_data), .ack(ack), .auto_eoi(auto_eoi),
    .rot_on_aeoi(rot_on_aeoi), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .int_out(int_out), .int_line(int_line), .irr(irr),
    .isr(isr), .imr(imr), .prio_base(prio_base)
  );

  // relative priority: rotate right by base, lowest set bit
  function automatic int relp(input logic [7:0] v, input logic [2:0] b);
    logic [15:0] dbl;
    logic [7:0]  rot;
    dbl = {v, v} >> b;
    rot = dbl[7:0];
    for (int i = 0; i < 8; i++) if (rot[i]) return i;
    return 8;
  endfunction

  function automatic logic [2:0] abs_line(input int rel, input logic [2:0] b);
    return 3'((rel + int'(b)) % 8);
  endfunction

  function automatic logic m_int();
    return relp(m_irr & ~m_imr, m_base) < relp(m_isr, m_base);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({"R4 int_out ", ctx}, int'(int_out), int'(m_int()));
    if (m_int()) chk({"R5 int_line ", ctx}, int'(int_line),
                     int'(abs_line(relp(m_irr & ~m_imr, m_base), m_base)));
    chk({"R1/R2/R8 irr ", ctx}, int'(irr), int'(m_irr));
    chk({"R6/R9/R10 isr ", ctx}, int'(isr), int'(m_isr));
    chk({"R14 imr ", ctx}, int'(imr), int'(m_imr));
    chk({"R7/R11 base ", ctx}, int'(prio_base), int'(m_base));
  endtask

  task automatic model_next();
    logic [7:0] rise;
    logic       fire;
    logic [2:0] wl, sl;
    int         sp;
    rise = req_in & ~m_prev;
    fire = ack && m_int();
    wl   = abs_line(relp(m_irr & ~m_imr, m_base), m_base);
    sp   = relp(m_isr, m_base);
    sl   = abs_line(sp, m_base);
    n_isr = m_isr; n_base = m_base;
    if (cmd_valid) begin
      case (cmd_op)
        3'd1: if (sp != 8) n_isr[sl] = 1'b0;
        3'd2: if (sp != 8) begin n_isr[sl] = 1'b0; n_base = sl + 3'd1; end
        3'd3: n_isr[cmd_line] = 1'b0;
        3'd4: begin n_isr[cmd_line] = 1'b0; n_base = cmd_line + 3'd1; end
        3'd5: n_base = cmd_line + 3'd1;
        default: ;
      endcase
    end
    if (fire) begin
      if (!auto_eoi) n_isr[wl] = 1'b1;
      else if (rot_on_aeoi) n_base = wl + 3'd1;
    end
    for (int i = 0; i < 8; i++) begin
      if (trig_level[i]) n_irr[i] = req_in[i];
      else n_irr[i] = (m_irr[i] & ~(fire && wl == 3'(i))) | rise[i];
    end
    n_prev = req_in;
    n_imr  = mask_we ? mask_data : m_imr;
  endtask

  task automatic step(input string ctx);
    model_next();
    @(posedge clk);
    m_irr = n_irr; m_prev = n_prev; m_isr = n_isr; m_imr = n_imr; m_base = n_base;
    @(negedge clk);
    check_all(ctx);
    ack = 1'b0; cmd_valid = 1'b0; mask_we = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] l);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = l;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check_all("R3 reset");
    rst_n = 1'b1;
    // R1 edge capture and no retrigger while held
    req_in = 8'h08; step("R1 rise");
    step("R1 held");
    ack = 1'b1; step("R6 R8 ack edge");
    step("R1 held after ack");
    // R2 level line, R4 strict compare against in-service line 3
    trig_level = 8'h20; req_in = 8'h28; step("R2 level R4 blocked");
    cmd(3'd1, 3'd0); step("R9 nonspecific eoi");
    ack = 1'b1; step("R8 level keeps request");
    req_in = 8'h08; step("R2 level drop");
    cmd(3'd3, 3'd5); step("R10 specific eoi");
    cmd(3'd5, 3'd4); step("R11 set base");
    cmd(3'd6, 3'd1); step("R11 unused code");
    req_in = 8'h4c; trig_level = 8'h00; step("R5 rotated winner");
    mask_we = 1'b1; mask_data = 8'hff; step("R14 mask all");
    ack = 1'b1; step("R13 ack while idle");
    mask_we = 1'b1; mask_data = 8'h00; step("R14 unmask");
    ack = 1'b1; cmd(3'd3, 3'd6); step("R12 eoi with ack");
    cmd(3'd4, 3'd6); step("R10 rotating specific");
    auto_eoi = 1'b1; rot_on_aeoi = 1'b1;
    ack = 1'b1; step("R7 aeoi rotate");
    rot_on_aeoi = 1'b0; req_in = 8'h4d; step("R1 new edge");
    ack = 1'b1; step("R7 aeoi no rotate");
    auto_eoi = 1'b0;
    cmd(3'd2, 3'd0); ack = 1'b1; step("R12 rotating eoi with ack");
    // sweep across every base value and random traffic
    r = 32'h1234_5678;
    for (int b = 0; b < 8; b++) begin
      cmd(3'd5, 3'(b)); step("R11 sweep base");
      for (int k = 0; k < 600; k++) begin
        r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
        req_in = req_in ^ (r[7:0] & r[15:8]);
        if (r[20:16] == 5'd0) trig_level = r[31:24];
        mask_we   = (r[23:21] == 3'd0);
        mask_data = r[31:24] & r[11:4];
        ack       = r[24];
        if (r[27:25] == 3'd0) cmd(r[30:28], r[2:0]);
        auto_eoi    = (b >= 4) && r[19];
        rot_on_aeoi = (b >= 6) || r[18];
        step("R4 R5 sweep");
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule